// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

This block is a presettable binary counter, four bits wide by default. It has no direction pin. Instead it takes two active-low count strobes, one that counts up and one that counts down. A step happens when one strobe is released (goes from low back to high) while the other strobe is idle high. Both strobes are sampled on a single system clock and edge-detected, so every bit of the count changes on the same clock edge.

Two level-sensitive overrides act on every clock: an active-high clear and an active-low parallel load. Clear has priority over load, and load has priority over counting.

Two active-low outputs, carry and borrow, are produced combinationally from the count and the sampled strobe levels. They let identical stages be chained with no glue logic. Carry of one stage drives the up strobe of the next, and borrow drives the down strobe. Reloading a preset value when a stage reaches a chosen value shortens its count length, which gives a divide-by-N.

Top module: `dual_strobe_counter`

## Requirements
- R1: After a synchronous reset, the count is 0 and both carry_n and borrow_n are high.
- R2: Suppose up_n is sampled low at one clock edge and high at the next, while dn_n is sampled high. Then the count rises by one on the clock edge after that.
- R3: Suppose dn_n is sampled low at one clock edge and high at the next, while up_n is sampled high. Then the count falls by one on the clock edge after that.
- R4: The count wraps from the maximum (all ones) to 0 when stepping up, and from 0 to the maximum when stepping down.
- R5: A strobe release has no effect in two cases: when the other strobe is sampled low at the same time, or when both strobes are released on the same sample. While both strobes are low, the count holds.
- R6: While clear is high, the count becomes 0 on the next clock edge, whatever the values of load_n, preset and the strobes.
- R7: While load_n is low and clear is low, the count takes the preset value on the next clock edge, and strobe releases are ignored.
- R8: carry_n is low exactly when two things hold: the count is at its maximum, and up_n was sampled low at the last clock edge. So its low pulse tracks the width of the up strobe, delayed by one clock.
- R9: borrow_n is low exactly when two things hold: the count is 0, and dn_n was sampled low at the last clock edge.
- R10: Two stages chained carry-to-up and borrow-to-down count as one wider counter. The upper stage steps one clock after the lower stage wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Active-high clear; forces the count to zero |
| load_n | input | 1 | Active-low parallel load |
| preset | input | WIDTH | Parallel load value |
| up_n | input | 1 | Active-low up-count strobe; a step happens on its release |
| dn_n | input | 1 | Active-low down-count strobe; a step happens on its release |
| count | output | WIDTH | Registered count value |
| carry_n | output | 1 | Active-low terminal-count pulse while counting up |
| borrow_n | output | 1 | Active-low terminal-count pulse while counting down |

## Verification
Strobes pass through a sampling register and then an edge register. A release driven between edges therefore shows in the count two clock edges later. Carry and borrow follow the sampled strobe level, one edge after the strobe is driven.

Clear and load take effect on the first edge after they are driven. In a chained pair, the upper stage samples the lower stage's carry or borrow, so it steps one edge after the lower stage.

The bench drives inputs one time unit after a rising edge. Each task waits exactly the number of edges stated above, then samples the outputs before the next edge. Each scenario is a directed task that checks its own results.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  // index of each strobe inside the sampled strobe vector
  localparam int NUM_STROBES = 2;
  localparam int IDX_UP      = 0;
  localparam int IDX_DN      = 1;

  // action applied to the count register on the next edge
  typedef enum logic [2:0] {
    ACT_HOLD   = 3'd0,
    ACT_INC    = 3'd1,
    ACT_DEC    = 3'd2,
    ACT_ZERO   = 3'd3,
    ACT_PRESET = 3'd4
  } act_e;
endpackage

// File: rtl/dsc_strobe_sampler.sv
module dsc_strobe_sampler #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] strobe_n,
  output logic [N-1:0] level,
  output logic [N-1:0] rel_p
);
  logic [N-1:0] level_d;

  for (genvar i = 0; i < N; i++) begin : g_strobe
    // idle level of a strobe is high, so reset both stages high
    always_ff @(posedge clk) begin
      if (rst) begin
        level[i]   <= 1'b1;
        level_d[i] <= 1'b1;
      end else begin
        level[i]   <= strobe_n[i];
        level_d[i] <= level[i];
      end
    end

    assign rel_p[i] = level[i] & ~level_d[i];

    // a release pulse lasts one cycle (R2, R3)
    assert_rel_single_R2: assert property (@(posedge clk) disable iff (rst)
      rel_p[i] |=> !rel_p[i]);
  end
endmodule

// File: rtl/dsc_step_decode.sv
module dsc_step_decode
  import dsc_pkg::*;
(
  input  logic                   clr,
  input  logic                   load_n,
  input  logic [NUM_STROBES-1:0] level,
  input  logic [NUM_STROBES-1:0] rel_p,
  output act_e                   act
);
  always_comb begin
    if (clr)
      act = ACT_ZERO;
    else if (!load_n)
      act = ACT_PRESET;
    else if (rel_p[IDX_UP] && !rel_p[IDX_DN] && level[IDX_DN])
      act = ACT_INC;
    else if (rel_p[IDX_DN] && !rel_p[IDX_UP] && level[IDX_UP])
      act = ACT_DEC;
    else
      act = ACT_HOLD;
  end
endmodule

// File: rtl/dsc_count_reg.sv
module dsc_count_reg
  import dsc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  act_e             act,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // modular arithmetic gives the wrap in both directions
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (act)
        ACT_ZERO:   q <= '0;
        ACT_PRESET: q <= preset;
        ACT_INC:    q <= q + ONE;
        ACT_DEC:    q <= q - ONE;
        default:    q <= q;
      endcase
    end
  end
endmodule

// File: rtl/dsc_cascade_out.sv
module dsc_cascade_out
  import dsc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]       q,
  input  logic [NUM_STROBES-1:0] level,
  output logic                   carry_n,
  output logic                   borrow_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  assign carry_n  = ~((q == TOP) & ~level[IDX_UP]);
  assign borrow_n = ~((q == '0)  & ~level[IDX_DN]);
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
  import dsc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             up_n,
  input  logic             dn_n,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic [NUM_STROBES-1:0] strobe_n;
  logic [NUM_STROBES-1:0] level;
  logic [NUM_STROBES-1:0] rel_p;
  act_e                   act;

  assign strobe_n[IDX_UP] = up_n;
  assign strobe_n[IDX_DN] = dn_n;

  dsc_strobe_sampler #(.N(NUM_STROBES)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (strobe_n),
    .level    (level),
    .rel_p    (rel_p)
  );

  dsc_step_decode u_decode (
    .clr    (clr),
    .load_n (load_n),
    .level  (level),
    .rel_p  (rel_p),
    .act    (act)
  );

  dsc_count_reg #(.WIDTH(WIDTH)) u_count (
    .clk    (clk),
    .rst    (rst),
    .act    (act),
    .preset (preset),
    .q      (count)
  );

  dsc_cascade_out #(.WIDTH(WIDTH)) u_cascade (
    .q        (count),
    .level    (level),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );

  // ---------------- assertions ----------------
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (count == '0));

  assert_step_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_n) |=> (count == $past(count) ||
                          count == $past(count) + ONE ||
                          count == $past(count) - ONE));

  assert_hold_both_low_R5: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_n && !level[IDX_UP] && !level[IDX_DN]) |=> $stable(count));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  assert_load_value_R7: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load_n) |=> (count == $past(preset)));

  assert_carry_at_top_R8: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> (count == TOP));

  assert_borrow_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> (count == '0));
endmodule

// File: tb/dual_strobe_counter_bench.sv
`timescale 1ns/1ps
module dual_strobe_counter_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         clr;
  logic         load_n;
  logic [W-1:0] preset;
  logic         up_n;
  logic         dn_n;
  logic [W-1:0] count;
  logic         carry_n;
  logic         borrow_n;

  // second stage for the cascade test
  logic         hi_clr;
  logic         hi_load_n;
  logic [W-1:0] hi_preset;
  logic [W-1:0] hi_count;
  logic         hi_carry_n;
  logic         hi_borrow_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dual_strobe_counter #(.WIDTH(W)) u_dual_strobe_counter (
    .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .preset(preset),
    .up_n(up_n), .dn_n(dn_n), .count(count),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );

  dual_strobe_counter #(.WIDTH(W)) u_hi (
    .clk(clk), .rst(rst), .clr(hi_clr), .load_n(hi_load_n), .preset(hi_preset),
    .up_n(carry_n), .dn_n(borrow_n), .count(hi_count),
    .carry_n(hi_carry_n), .borrow_n(hi_borrow_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance one rising edge, then settle 1 ns past it
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_both(input int lo, input int hi);
    load_n = 1'b0; preset = W'(lo);
    hi_load_n = 1'b0; hi_preset = W'(hi);
    tick();
    load_n = 1'b1; hi_load_n = 1'b1;
    tick();
  endtask

  // pulse one strobe low for one sample, release, then wait for the step
  task automatic pulse_up();
    up_n = 1'b0; tick();
    up_n = 1'b1; tick(); tick();
  endtask

  task automatic pulse_dn();
    dn_n = 1'b0; tick();
    dn_n = 1'b1; tick(); tick();
  endtask

  task automatic t_reset();
    check("R1 count", int'(count), 0);
    check("R1 carry_n", int'(carry_n), 1);
    check("R1 borrow_n", int'(borrow_n), 1);
  endtask

  task automatic t_up_down();
    load_both(5, 0);
    pulse_up();
    check("R2 up step", int'(count), 6);
    pulse_up();
    check("R2 second up step", int'(count), 7);
    pulse_dn();
    check("R3 down step", int'(count), 6);
  endtask

  task automatic t_wrap_and_pulses();
    load_both(15, 0);
    up_n = 1'b0; tick();
    check("R8 carry low while up held at top", int'(carry_n), 0);
    tick();
    check("R8 carry stays low with strobe", int'(carry_n), 0);
    up_n = 1'b1; tick();
    check("R8 carry released with strobe", int'(carry_n), 1);
    tick();
    check("R4 wrap top to zero", int'(count), 0);
    dn_n = 1'b0; tick();
    check("R9 borrow low while down held at zero", int'(borrow_n), 0);
    dn_n = 1'b1; tick();
    check("R9 borrow released with strobe", int'(borrow_n), 1);
    tick();
    check("R4 wrap zero to top", int'(count), 15);
    check("R8 carry high with up idle at top", int'(carry_n), 1);
  endtask

  task automatic t_ignored();
    load_both(9, 0);
    dn_n = 1'b0;
    up_n = 1'b0; tick();
    up_n = 1'b1; tick(); tick();
    check("R5 up release with down held low", int'(count), 9);
    up_n = 1'b0; dn_n = 1'b0; tick(); tick();
    check("R5 both low holds", int'(count), 9);
    up_n = 1'b1; dn_n = 1'b1; tick(); tick();
    check("R5 simultaneous release holds", int'(count), 9);
  endtask

  task automatic t_clear();
    load_both(11, 0);
    clr = 1'b1; load_n = 1'b0; preset = 4'd6; up_n = 1'b0;
    tick();
    check("R6 clear beats load", int'(count), 0);
    up_n = 1'b1; tick(); tick();
    check("R6 clear beats strobe release", int'(count), 0);
    clr = 1'b0; load_n = 1'b1;
    tick();
  endtask

  task automatic t_load();
    load_n = 1'b0; preset = 4'd12;
    tick();
    check("R7 load value", int'(count), 12);
    up_n = 1'b0; tick();
    up_n = 1'b1; tick(); tick();
    check("R7 strobe ignored during load", int'(count), 12);
    preset = 4'd3; tick();
    check("R7 load follows preset", int'(count), 3);
    load_n = 1'b1; tick();
  endtask

  task automatic t_cascade();
    load_both(15, 2);
    pulse_up();
    check("R10 low stage wraps", int'(count), 0);
    check("R10 high stage not yet", int'(hi_count), 2);
    tick();
    check("R10 high stage counts up", int'(hi_count), 3);
    pulse_dn();
    check("R10 low stage wraps down", int'(count), 15);
    tick();
    check("R10 high stage counts down", int'(hi_count), 2);
  endtask

  initial begin
    rst = 1'b1; clr = 1'b0; load_n = 1'b1; preset = '0;
    up_n = 1'b1; dn_n = 1'b1;
    hi_clr = 1'b0; hi_load_n = 1'b1; hi_preset = '0;
    tick(); tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_up_down();
    t_wrap_and_pulses();
    t_ignored();
    t_clear();
    t_load();
    t_cascade();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule